// File: doc/BRIEF.md
# I2C Slave Receiver with Buffer-Occupancy Clock Stretching

This block is the receive side of an I2C target. It watches already-synchronized SDA and SCL levels, detects START and STOP conditions, and shifts in an address byte followed by data bytes, most significant bit first. When the address byte names this target and carries the write direction, the block acknowledges it and then accepts data bytes into a single receive buffer that the host drains with a one-cycle read strobe.

The buffer is the only place a completed byte can be handed over. Incoming bits collect in a separate shift register, so a finished byte can wait there while the buffer still holds its predecessor. In that case the block pulls SCL low and withholds the acknowledge. The master, if it honours stretching, simply waits, for any length of time. When the host reads the buffer, the waiting byte moves into it, SDA is pulled low for the acknowledge, and SCL is let go one clock later. A byte is only acknowledged once it sits in the buffer, so no received byte is ever overwritten or dropped.

Both lines are driven as open-drain pull-down enables. A frame whose address does not match, or that asks for a read, is ignored until the next START.

Top module: `i2c_stall_rx`

## Requirements
- R1: After synchronous reset both pull-down enables are low, `rx_valid` is low and `stretching` is low.
- R2: A first byte after START whose upper seven bits (sent first) equal `own_addr` and whose last bit is 0 is acknowledged: SDA is pulled low from the SCL falling edge ending bit 8 until the next SCL falling edge.
- R3: A first byte whose address differs, or whose last bit is 1, gets no acknowledge. The block then drives neither line and loads nothing into the buffer until the next START.
- R4: A data byte that completes while the buffer is empty is loaded into `rx_data`, sets `rx_valid`, and is acknowledged.
- R5: A `rd_strobe` pulse with no byte being loaded in the same cycle clears `rx_valid` on the next clock.
- R6: A data byte that completes while `rx_valid` is high makes the block hold SCL low and raise `stretching`. No acknowledge is given and `rx_data` keeps the unread byte for as long as no read occurs.
- R7: A read during the stall moves the waiting byte into `rx_data` with `rx_valid` high and pulls SDA low on the next clock. SCL is held one further clock and then released, and `stretching` drops together with the read.
- R8: The SDA pull-down for a data acknowledge is released at the SCL falling edge that ends the acknowledge clock, and reception of the next byte follows.
- R9: A START at any point restarts bit counting with a new address byte. A STOP returns the block to idle with both lines released.
- R10: `rx_data` is never replaced while `rx_valid` is high unless a read is made in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Synchronized SDA line level |
| scl_in | input | 1 | Synchronized SCL line level |
| own_addr | input | 7 | Target address to match |
| rd_strobe | input | 1 | One-cycle pulse: host takes the buffer |
| sda_pull | output | 1 | 1 = pull SDA low |
| scl_pull | output | 1 | 1 = pull SCL low |
| rx_data | output | 8 | Receive buffer contents |
| rx_valid | output | 1 | Receive buffer holds an unread byte |
| stretching | output | 1 | SCL is held low waiting for a buffer read |

## Verification
Line edges act on the first clock edge that sees the new level. The acknowledge pull, a buffer load and the stall therefore appear one clock after an SCL fall reaches the inputs, and the bench waits several clocks after each line change before it samples on the falling clock edge. After a read in a stall, `rx_data`, `rx_valid` and the SDA pull are due one clock after the strobe, with SCL still low in that cycle and free in the following one. The bench samples exactly on those two cycles. The master model in the bench waits on the wired-AND SCL level, so a stall of hundreds of clocks is observed at the lines and not assumed.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_ADDR,
        FR_AACK,
        FR_DATA,
        FR_STALL,
        FR_REL,
        FR_DACK,
        FR_SKIP
    } fr_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] own);
        return (b[BYTE_W-1:BYTE_W-ADDR_W] == own) && !b[0];
    endfunction

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events
    import i2c_srx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sda_i,
    input  logic     scl_i,
    output line_ev_t ev_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.scl_rise = scl_i & ~scl_q;
        ev_o.scl_fall = ~scl_i & scl_q;
        ev_o.start    = scl_i & scl_q & sda_q & ~sda_i;
        ev_o.stop     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2c_rx_holding.sv
module i2c_rx_holding
    import i2c_srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              rd_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              valid_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else if (load_i) begin
            data_o  <= data_i;
            valid_o <= 1'b1;
        end else if (rd_i) begin
            valid_o <= 1'b0;
        end
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (!valid_o || rd_i)); // R10

    AST_HOLD_UNREAD: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !rd_i) |=> $stable(data_o)); // R10

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !load_i) |=> !valid_o); // R5

endmodule

// File: rtl/i2c_rx_frame.sv
module i2c_rx_frame
    import i2c_srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              buf_valid_i,
    input  logic              rd_i,
    output logic              load_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              sda_hold_o,
    output logic              scl_hold_o,
    output logic              stretching_o
);
    fr_state_e         st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              byte_done;
    logic              room;

    assign byte_done = ev_i.scl_fall && (cnt_q == CNT_W'(BYTE_W));
    assign room      = !buf_valid_i || rd_i;

    always_comb begin
        load_o = 1'b0;
        if (st_q == FR_DATA && byte_done && room)
            load_o = 1'b1;
        else if (st_q == FR_STALL && rd_i)
            load_o = 1'b1;
    end

    assign byte_o       = sh_q;
    assign sda_hold_o   = (st_q == FR_AACK) || (st_q == FR_DACK) || (st_q == FR_REL);
    assign scl_hold_o   = (st_q == FR_STALL) || (st_q == FR_REL);
    assign stretching_o = (st_q == FR_STALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FR_IDLE;
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (ev_i.start) begin
            st_q  <= FR_ADDR;
            cnt_q <= '0;
        end else if (ev_i.stop) begin
            st_q  <= FR_IDLE;
            cnt_q <= '0;
        end else begin
            if ((st_q == FR_ADDR || st_q == FR_DATA) && ev_i.scl_rise
                && cnt_q != CNT_W'(BYTE_W)) begin
                sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
                cnt_q <= cnt_q + 1'b1;
            end
            case (st_q)
                FR_ADDR: if (byte_done)
                    st_q <= addr_hit(sh_q, own_addr_i) ? FR_AACK : FR_SKIP;
                FR_AACK, FR_DACK: if (ev_i.scl_fall) begin
                    st_q  <= FR_DATA;
                    cnt_q <= '0;
                end
                FR_DATA: if (byte_done)
                    st_q <= room ? FR_DACK : FR_STALL;
                FR_STALL: if (rd_i)
                    st_q <= FR_REL;
                FR_REL:
                    st_q <= FR_DACK;
                default: ;
            endcase
        end
    end

    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        (st_q == FR_STALL) |-> buf_valid_i); // R6

    AST_ACK_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_hold_o) |-> sda_hold_o); // R7

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        ev_i.stop |=> (!sda_hold_o && !scl_hold_o)); // R9

    AST_SKIP_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (st_q == FR_SKIP || st_q == FR_IDLE) |-> !load_o); // R3

endmodule

// File: rtl/i2c_stall_rx.sv
module i2c_stall_rx
    import i2c_srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rd_strobe,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              stretching
);
    line_ev_t          ev;
    logic              load;
    logic [BYTE_W-1:0] pend_byte;

    i2c_line_events u_events (
        .clk   (clk),
        .rst   (rst),
        .sda_i (sda_in),
        .scl_i (scl_in),
        .ev_o  (ev)
    );

    i2c_rx_frame u_frame (
        .clk          (clk),
        .rst          (rst),
        .ev_i         (ev),
        .sda_i        (sda_in),
        .own_addr_i   (own_addr),
        .buf_valid_i  (rx_valid),
        .rd_i         (rd_strobe),
        .load_o       (load),
        .byte_o       (pend_byte),
        .sda_hold_o   (sda_pull),
        .scl_hold_o   (scl_pull),
        .stretching_o (stretching)
    );

    i2c_rx_holding u_buf (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .data_i  (pend_byte),
        .rd_i    (rd_strobe),
        .data_o  (rx_data),
        .valid_o (rx_valid)
    );

    AST_SCL_MEANS_FULL: assert property (@(posedge clk) disable iff (rst)
        (stretching && !rd_strobe) |=> (rx_valid && scl_pull)); // R6

endmodule

// File: tb/i2c_stall_rx_test.sv
module i2c_stall_rx_test;
    localparam int Q = 5;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sda_m = 1'b1, scl_m = 1'b1, rd = 1'b0;
    logic sda_pull, scl_pull, rx_valid, stretching;
    logic [7:0] rx_data;
    logic sda_line, scl_line;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign scl_line = scl_m & ~scl_pull;

    i2c_stall_rx uut (
        .clk(clk), .rst(rst), .sda_in(sda_line), .scl_in(scl_line),
        .own_addr(OWN), .rd_strobe(rd), .sda_pull(sda_pull),
        .scl_pull(scl_pull), .rx_data(rx_data), .rx_valid(rx_valid),
        .stretching(stretching)
    );

    // {first byte, data byte, expect acknowledge}
    localparam logic [16:0] VEC [6] = '{
        {8'hB4, 8'hC3, 1'b1},
        {8'hB5, 8'h11, 1'b0},
        {8'h34, 8'h22, 1'b0},
        {8'hB4, 8'h00, 1'b1},
        {8'hB4, 8'hFF, 1'b1},
        {8'hB6, 8'h5A, 1'b0}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1;
        while (!scl_line) @(negedge clk);
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic ack_clock(output logic a);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1;
        while (!scl_line) @(negedge clk);
        wait_q();
        a = ~sda_line;
        scl_m = 1'b0; wait_q();
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic a;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!sda_pull && !scl_pull, "R1 pulls", {sda_pull, scl_pull}, 0);
        chk(!rx_valid && !stretching, "R1 flags", {rx_valid, stretching}, 0);

        // table walk: R2 R3 R4 R5 R8
        for (int k = 0; k < 6; k++) begin
            logic [7:0] ab, db;
            logic ex;
            {ab, db, ex} = VEC[k];
            i2c_start();
            send_byte(ab);
            ack_clock(a);
            chk(a == ex, ex ? "R2 addr ack" : "R3 addr nack", a, ex);
            send_byte(db);
            ack_clock(a);
            chk(a == ex, ex ? "R4 data ack" : "R3 data nack", a, ex);
            chk(sda_line, "R8 sda released", sda_line, 1);
            if (ex) begin
                chk(rx_valid && rx_data == db, "R4 load", rx_data, db);
                pulse_rd();
                @(negedge clk);
                chk(!rx_valid, "R5 read clears", rx_valid, 0);
            end else begin
                chk(!rx_valid && !scl_pull, "R3 ignored", {rx_valid, scl_pull}, 0);
            end
            i2c_stop();
            chk(!sda_pull && !scl_pull, "R9 stop idle", {sda_pull, scl_pull}, 0);
        end

        // stall: R6 R7 R8 R10
        i2c_start();
        send_byte({OWN, 1'b0});
        ack_clock(a);
        send_byte(8'hA5);
        ack_clock(a);
        chk(a && rx_data == 8'hA5, "R4 first byte", rx_data, 8'hA5);
        send_byte(8'h3C);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1;
        repeat (300) @(negedge clk);
        chk(!scl_line && scl_pull, "R6 scl held", scl_line, 0);
        chk(stretching, "R6 stretching", stretching, 1);
        chk(sda_line, "R6 no ack yet", sda_line, 1);
        chk(rx_valid && rx_data == 8'hA5, "R10 buffer kept", rx_data, 8'hA5);
        rd = 1'b1;
        @(negedge clk) rd = 1'b0;
        chk(rx_valid && rx_data == 8'h3C, "R7 byte moved", rx_data, 8'h3C);
        chk(!sda_line, "R7 ack driven", sda_line, 0);
        chk(!scl_line, "R7 scl one more clock", scl_line, 0);
        chk(!stretching, "R7 stretching drops", stretching, 0);
        @(negedge clk);
        chk(scl_line, "R7 scl released", scl_line, 1);
        wait_q();
        scl_m = 1'b0; wait_q();
        chk(sda_line && !sda_pull, "R8 ack released", sda_pull, 0);
        pulse_rd();
        send_byte(8'h81);
        ack_clock(a);
        chk(a && rx_data == 8'h81, "R8 next byte", rx_data, 8'h81);
        pulse_rd();

        // repeated START mid-byte: R9
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        i2c_start();
        send_byte({OWN, 1'b0});
        ack_clock(a);
        chk(a, "R9 restart addr ack", a, 1);
        send_byte(8'h6E);
        ack_clock(a);
        chk(a && rx_data == 8'h6E, "R9 restart data", rx_data, 8'h6E);
        i2c_stop();
        chk(!sda_pull && !scl_pull, "R9 final stop", {sda_pull, scl_pull}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule